// File: doc/BRIEF.md
# Dual-Line Interrupt Aggregation Controller

This block gathers 32 peripheral request lines into two processor-facing lines. One line is low priority and one is high priority. Each request line is watched for a rising edge, and every edge sets a pending bit that stays set until software acknowledges it. A per-source enable mask decides which pending bits may reach the processor. A per-source route bit then sends each enabled source to the low-priority line or to the high-priority line.

Software reaches the block over a plain 32-bit register bus. The bus has a write strobe, a read strobe and a 3-bit word address. The enable mask cannot be written as a whole word. Bits are turned on through a write-one-to-set register and turned off through a write-one-to-clear register. This lets separate drivers change their own sources without a read-modify-write. Each line has its own status register, so a handler reads only the sources routed to its line.

Top module: `intr_fanin_ctrl`

## Requirements
- R1: After reset every enable bit, route bit and pending bit is 0, and both output lines are low.
- R2: A write to word 5 (enable-set) sets each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R3: A write to word 6 (enable-clear) clears each enable bit whose data bit is 1 and leaves the others unchanged. Writing 0xFFFFFFFF clears all enable bits.
- R4: Word 4 (route) is read/write. Route bit k = 1 sends source k to the high-priority line. Route bit k = 0 sends it to the low-priority line.
- R5: Word 2 reads pending & enable & ~route (low status). Word 3 reads pending & enable & route (high status).
- R6: Word 0 reads the pending bits whatever the enable and route bits hold. Word 1 reads the current enable bits.
- R7: A write to word 7 (acknowledge) clears each pending bit whose data bit is 1 and leaves the others unchanged.
- R8: A pending bit is set by a 0-to-1 change of its source input. A source held high does not set its bit again after an acknowledge. A rising edge in the same cycle as that bit's acknowledge leaves the bit set.
- R9: `irq_lo_o` is the registered OR of the low status bits and `irq_hi_o` is the registered OR of the high status bits. Each line changes one clock after the status changes.
- R10: A read strobe returns the addressed word on `rdata_o` after the next clock edge, and 0 when no read is strobed. Reads of words 5, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Peripheral request lines, one bit per source |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_lo_o | output | 1 | Low-priority interrupt line |
| irq_hi_o | output | 1 | High-priority interrupt line |

## Verification
Two events can hit the same pending bit in the same cycle: a new rising edge on a source, and the software acknowledge that clears it. The bench first leaves a source's bit pending. It then raises that source at the same falling edge where it drives an acknowledge write for the same bit, so both reach the same rising clock edge. Reading the raw pending word afterwards must show the bit still set. A second acknowledge, with the source still held high, must then clear the bit, which shows that a steady level does not set it again.

// File: rtl/intr_fanin_pkg.sv
package intr_fanin_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_RAW      = 3'd0,
    REG_ENABLE   = 3'd1,
    REG_LO_STAT  = 3'd2,
    REG_HI_STAT  = 3'd3,
    REG_ROUTE    = 3'd4,
    REG_EN_SET   = 3'd5,
    REG_EN_CLR   = 3'd6,
    REG_ACK      = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/intr_edge_latch.sv
module intr_edge_latch #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] src_q;

  for (genvar k = 0; k < N; k++) begin : g_src
    logic rise;
    assign rise = src_i[k] & ~src_q[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q[k]  <= 1'b0;
        pend_o[k] <= 1'b0;
      end else begin
        src_q[k]  <= src_i[k];
        // a fresh edge wins over a same-cycle acknowledge
        pend_o[k] <= rise | (pend_o[k] & ~ack_i[k]);
      end
    end
  end
endmodule

// File: rtl/intr_regfile.sv
module intr_regfile
  import intr_fanin_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      pend_i,
  input  logic [N-1:0]      lo_stat_i,
  input  logic [N-1:0]      hi_stat_i,
  output logic [N-1:0]      enable_o,
  output logic [N-1:0]      route_o,
  output logic [N-1:0]      ack_o,
  output logic [N-1:0]      rdata_o
);
  reg_sel_e     sel;
  logic [N-1:0] rd_val;

  assign sel   = reg_sel_e'(addr_i);
  assign ack_o = (wr_en_i && sel == REG_ACK) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_o <= '0;
      route_o  <= '0;
    end else if (wr_en_i) begin
      unique case (sel)
        REG_EN_SET: enable_o <= enable_o | wdata_i;
        REG_EN_CLR: enable_o <= enable_o & ~wdata_i;
        REG_ROUTE:  route_o  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      REG_RAW:     rd_val = pend_i;
      REG_ENABLE:  rd_val = enable_o;
      REG_LO_STAT: rd_val = lo_stat_i;
      REG_HI_STAT: rd_val = hi_stat_i;
      REG_ROUTE:   rd_val = route_o;
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_en_i ? rd_val : '0;
  end
endmodule

// File: rtl/intr_out_stage.sv
module intr_out_stage #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] enable_i,
  input  logic [N-1:0] route_i,
  output logic [N-1:0] lo_stat_o,
  output logic [N-1:0] hi_stat_o,
  output logic         irq_lo_o,
  output logic         irq_hi_o
);
  logic [N-1:0] live;

  assign live      = pend_i & enable_i;
  assign lo_stat_o = live & ~route_i;
  assign hi_stat_o = live & route_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_lo_o <= 1'b0;
      irq_hi_o <= 1'b0;
    end else begin
      irq_lo_o <= |lo_stat_o;
      irq_hi_o <= |hi_stat_o;
    end
  end
endmodule

// File: rtl/intr_fanin_ctrl.sv
module intr_fanin_ctrl
  import intr_fanin_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               irq_lo_o,
  output logic               irq_hi_o
);
  logic [NUM_SRC-1:0] pend_q, enable_q, route_q, ack, lo_stat, hi_stat;

  intr_edge_latch #(.N(NUM_SRC)) i_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .ack_i  (ack),
    .pend_o (pend_q)
  );

  intr_regfile #(.N(NUM_SRC)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .pend_i    (pend_q),
    .lo_stat_i (lo_stat),
    .hi_stat_i (hi_stat),
    .enable_o  (enable_q),
    .route_o   (route_q),
    .ack_o     (ack),
    .rdata_o   (rdata_o)
  );

  intr_out_stage #(.N(NUM_SRC)) i_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (pend_q),
    .enable_i  (enable_q),
    .route_i   (route_q),
    .lo_stat_o (lo_stat),
    .hi_stat_o (hi_stat),
    .irq_lo_o  (irq_lo_o),
    .irq_hi_o  (irq_hi_o)
  );
endmodule

// File: rtl/intr_fanin_chk.sv
module intr_fanin_chk #(
  parameter int unsigned N = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] src_i,
  input logic         wr_en_i,
  input logic         rd_en_i,
  input logic [2:0]   addr_i,
  input logic [N-1:0] wdata_i,
  input logic [N-1:0] rdata_o,
  input logic [N-1:0] pend_i,
  input logic [N-1:0] enable_i,
  input logic [N-1:0] route_i,
  input logic         irq_lo_o,
  input logic         irq_hi_o
);
  assert_en_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd5) |=> ((enable_i & $past(wdata_i)) == $past(wdata_i)));

  assert_en_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd6) |=> ((enable_i & $past(wdata_i)) == '0));

  assert_ack_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd7) |=> ((pend_i & $past(wdata_i) & ~$past(src_i)) == '0));

  assert_pend_from_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & ~$past(pend_i) & ~$past(src_i)) == '0));

  assert_lo_line_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_lo_o == $past(|(pend_i & enable_i & ~route_i)));

  assert_hi_line_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi_o == $past(|(pend_i & enable_i & route_i)));

  assert_wo_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i >= 3'd5) |=> (rdata_o == '0));

  assert_idle_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (rdata_o == '0));
endmodule

bind intr_fanin_ctrl intr_fanin_chk #(.N(NUM_SRC)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .src_i    (src_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .pend_i   (pend_q),
  .enable_i (enable_q),
  .route_i  (route_q),
  .irq_lo_o (irq_lo_o),
  .irq_hi_o (irq_hi_o)
);

// File: tb/test_intr_fanin_ctrl.sv
`timescale 1ns/1ps
module test_intr_fanin_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_lo_o, irq_hi_o;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] rv;

  always #2.5 clk_i = ~clk_i;

  intr_fanin_ctrl i_intr_fanin_ctrl (
    .clk_i, .rst_ni, .src_i, .wr_en_i, .rd_en_i, .addr_i,
    .wdata_i, .rdata_o, .irq_lo_o, .irq_hi_o
  );

  typedef struct packed {
    logic [31:0] en;
    logic [31:0] route;
    logic [31:0] src;
    logic [31:0] lo;
    logic [31:0] hi;
    logic        out_lo;
    logic        out_hi;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 1'b0, 1'b1},
    '{32'h0000_FFFF, 32'h00FF_00FF, 32'hF0F0_F0F0, 32'h0000_F000, 32'h0000_00F0, 1'b1, 1'b1},
    '{32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
    '{32'hAAAA_AAAA, 32'h5555_5555, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h0000_0000, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 irq_lo", {31'b0, irq_lo_o}, 32'd0);
    check("R1 irq_hi", {31'b0, irq_hi_o}, 32'd0);
    rd(3'd0, rv); check("R1 pending", rv, 32'd0);
    rd(3'd1, rv); check("R1 enable", rv, 32'd0);
    rd(3'd4, rv); check("R1 route", rv, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(3'd0, rv); check("R1 pending after release", rv, 32'd0);

    // vector walk: R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i); src_i = '0;
      wr(3'd6, 32'hFFFF_FFFF);
      wr(3'd7, 32'hFFFF_FFFF);
      wr(3'd4, VECS[i].route);
      wr(3'd5, VECS[i].en);
      src_i = VECS[i].src;
      @(negedge clk_i); @(negedge clk_i);
      check($sformatf("R9 lo line v%0d", i), {31'b0, irq_lo_o}, {31'b0, VECS[i].out_lo});
      check($sformatf("R9 hi line v%0d", i), {31'b0, irq_hi_o}, {31'b0, VECS[i].out_hi});
      rd(3'd0, rv); check($sformatf("R6 raw v%0d", i), rv, VECS[i].src);
      rd(3'd1, rv); check($sformatf("R6 enable v%0d", i), rv, VECS[i].en);
      rd(3'd4, rv); check($sformatf("R4 route v%0d", i), rv, VECS[i].route);
      rd(3'd2, rv); check($sformatf("R5 lo stat v%0d", i), rv, VECS[i].lo);
      rd(3'd3, rv); check($sformatf("R5 hi stat v%0d", i), rv, VECS[i].hi);
    end

    // R2 / R3 partial set and clear
    @(negedge clk_i); src_i = '0;
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    wr(3'd4, 32'h0);
    wr(3'd5, 32'h0000_000F);
    wr(3'd5, 32'h0000_00F0);
    rd(3'd1, rv); check("R2 set keeps others", rv, 32'h0000_00FF);
    wr(3'd6, 32'h0000_0003);
    rd(3'd1, rv); check("R3 clear keeps others", rv, 32'h0000_00FC);

    // R3: clearing an enable drops the line but keeps pending
    src_i = 32'h0000_0004;
    @(negedge clk_i); @(negedge clk_i);
    check("R9 line from bit2", {31'b0, irq_lo_o}, 32'd1);
    wr(3'd6, 32'h0000_0004);
    @(negedge clk_i);
    check("R3 line low after clear", {31'b0, irq_lo_o}, 32'd0);
    rd(3'd0, rv); check("R3 pending kept", rv, 32'h0000_0004);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd1, rv); check("R3 clear all", rv, 32'h0);

    // R7 acknowledge only the written bit
    src_i = 32'h0000_0007;
    @(negedge clk_i);
    wr(3'd7, 32'h0000_0001);
    rd(3'd0, rv); check("R7 ack bit0 only", rv, 32'h0000_0006);

    // R8 held level is not re-latched
    wr(3'd7, 32'h0000_0002);
    @(negedge clk_i);
    rd(3'd0, rv); check("R8 held level no re-pend", rv, 32'h0000_0004);

    // R8 edge coincident with acknowledge of bit 2
    src_i = 32'h0;
    @(negedge clk_i);
    src_i = 32'h0000_0004;
    wr_en_i = 1'b1; addr_i = 3'd7; wdata_i = 32'h0000_0004;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
    rd(3'd0, rv); check("R8 edge beats ack", rv, 32'h0000_0004);
    wr(3'd7, 32'h0000_0004);
    rd(3'd0, rv); check("R8 ack with source high", rv, 32'h0);

    // R9 line falls one clock after acknowledge
    wr(3'd4, 32'h0000_0100);
    wr(3'd5, 32'h0000_0100);
    src_i = 32'h0000_0100;
    @(negedge clk_i); @(negedge clk_i);
    check("R9 hi line set", {31'b0, irq_hi_o}, 32'd1);
    wr(3'd7, 32'h0000_0100);
    check("R9 hi line still high", {31'b0, irq_hi_o}, 32'd1);
    @(negedge clk_i);
    check("R9 hi line low", {31'b0, irq_hi_o}, 32'd0);

    // R10 write-only words and idle bus
    rd(3'd5, rv); check("R10 read word5", rv, 32'h0);
    rd(3'd6, rv); check("R10 read word6", rv, 32'h0);
    rd(3'd7, rv); check("R10 read word7", rv, 32'h0);
    @(negedge clk_i);
    check("R10 idle rdata", rdata_o, 32'h0);

    summary();
  end
endmodule